// File: doc/BRIEF.md
# Display Fetch Address Generator

This block produces the video-memory fetch address for every character clock of the active picture. An external timing generator supplies three strobes: one at the start of each frame, one at each scan-line boundary and one per character clock. The block uses them to keep a row base address, a running character address, a row-scan counter and a scan-line counter. Each character address is then remapped into the memory address that is presented to the display memory.

The remapping covers three address units: byte, word (rotated up by one) and doubleword (rotated up by two). It can substitute row-scan bits into address bits 13 and 14, which gives two-bank and four-bank interleaved layouts. It supports scan-line repetition, half-rate row stepping, half-rate character stepping, a per-line byte pan and a split screen that restarts addressing from zero at a programmable line.

The output is a valid-qualified stream with no ready input. Display timing cannot be stalled, so a consumer must accept every beat in the cycle it appears. Configuration inputs are plain levels and are sampled on every clock.

Top module: `vga_fetch_addr`

## Requirements
- R1: While `rst_n` is low or `run` is low, `fetch_valid` is 0 and `scan_row` is 0. All counters clear: the scan-line count, the row base and the character address are zero, and every phase toggle is cleared.
- R2: A `frame_start` strobe while running loads the following values:
  - row base ← `start_addr`
  - character address ← `start_addr + byte_pan`
  - `scan_row` ← `preset_scan`
  - scan-line count ← 0
  - all phase toggles ← 0
- R3: A `char_tick` strobe on its own produces `fetch_valid`=1 in the next cycle, together with the remapped current character address. The character address then increments by 1. When `char_half`=1 it increments only on every second tick; the first tick after a load does not increment.
- R4: The address unit follows these rules:
  - `sel_dword`=1 selects doubleword, and the output address is `{a[13:0],a[15:14]}`.
  - Otherwise `sel_byte`=0 selects word, with the output address described in R5.
  - Otherwise the unit is byte, and the output address is `a`.
  - The row stride is `line_offset`×K, with K=2, 4 or 8 for byte, word or doubleword.
- R5: In word unit the output address is `{a[14:0],b}`, where b is `a[15]` when `wrap_hi`=1 and `a[13]` otherwise.
- R6: After the rotation, `bank0_n`=0 replaces output bit 13 with `scan_row[0]`, and `bank1_n`=0 replaces output bit 14 with `scan_row[1]`.
- R7: A `line_start` scan step that advances the row does one of two things:
  - If `scan_row`==`max_scan`, it clears `scan_row` and adds the stride to the row base.
  - Otherwise it increments `scan_row`.
  
  On every `line_start`, the character address reloads to row base + `byte_pan`.
- R8: With `dbl_scan`=1 every second `line_start` (the first after a load excluded) is a scan step; the others repeat the line. With `scan_half`=1 a row advance happens only on every second scan step.
- R9: On `line_start`, the scan-line count increments modulo 1024. If the new count equals `line_cmp`, the block starts a split screen:
  - row base ← 0
  - `scan_row` ← 0
  - phase toggles ← 0
  - character address ← `byte_pan`
  
  This overrides any row advance in the same cycle.
- R10: `frame_start` takes priority over `line_start`, and `line_start` takes priority over `char_tick`. A `char_tick` coinciding with either of the other strobes is dropped, and `fetch_valid` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Frame start strobe |
| line_start | input | 1 | Scan-line boundary strobe |
| char_tick | input | 1 | Character clock strobe |
| start_addr | input | 16 | Display start address |
| line_offset | input | 8 | Row pitch in units of K |
| preset_scan | input | 5 | Initial row scan at frame start |
| byte_pan | input | 2 | Character address skip at each line start |
| max_scan | input | 5 | Scan lines per row minus one |
| dbl_scan | input | 1 | Show each scan line twice |
| sel_dword | input | 1 | Doubleword address unit |
| sel_byte | input | 1 | Byte unit when not doubleword (0 = word) |
| wrap_hi | input | 1 | Word-mode low bit taken from bit 15 instead of 13 |
| bank0_n | input | 1 | Low: bit 13 from scan_row[0] |
| bank1_n | input | 1 | Low: bit 14 from scan_row[1] |
| scan_half | input | 1 | Advance rows on every second scan step |
| char_half | input | 1 | Advance character address every second tick |
| run | input | 1 | Low holds the block cleared |
| line_cmp | input | 10 | Split-screen line |
| fetch_valid | output | 1 | Fetch address valid |
| fetch_addr | output | 16 | Remapped fetch address |
| scan_row | output | 5 | Current row-scan count |

## Verification
Two functions can land on the same `line_start`: the split-screen restart and a row wrap that adds the stride to the base. The bench provokes this by setting `max_scan` so that a row ends exactly on the line whose count equals `line_cmp`. It then judges that the base becomes zero rather than advancing. A second collision is a `char_tick` issued together with `line_start` or `frame_start`. The reference model expects that beat to vanish while the reload still happens. Random strobe traffic across all mode bits exercises further overlaps, and each cycle is compared against the reference model.

// File: rtl/vga_ag_pkg.sv
package vga_ag_pkg;

  typedef enum logic [1:0] {
    UNIT_BYTE  = 2'd0,
    UNIT_WORD  = 2'd1,
    UNIT_DWORD = 2'd2
  } addr_unit_e;

  // Doubleword selection wins over the byte/word choice.
  function automatic addr_unit_e pick_unit(input logic sel_dword, input logic sel_byte);
    if (sel_dword)     return UNIT_DWORD;
    else if (sel_byte) return UNIT_BYTE;
    else               return UNIT_WORD;
  endfunction

  // Left shift that turns the row pitch into a stride (K = 2, 4, 8).
  function automatic logic [1:0] unit_shift(input addr_unit_e u);
    case (u)
      UNIT_DWORD: return 2'd3;
      UNIT_WORD:  return 2'd2;
      default:    return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/vga_row_seq.sv
module vga_row_seq
  import vga_ag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8,
  parameter int SCAN_W = 5,
  parameter int LINE_W = 10,
  parameter int PAN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [OFF_W-1:0]  line_offset,
  input  addr_unit_e        unit,
  input  logic [SCAN_W-1:0] preset_scan,
  input  logic [SCAN_W-1:0] max_scan,
  input  logic              dbl_scan,
  input  logic              scan_half,
  input  logic [LINE_W-1:0] line_cmp,
  input  logic [PAN_W-1:0]  byte_pan,
  output logic              load_en,
  output logic [ADDR_W-1:0] load_val,
  output logic [SCAN_W-1:0] scan_row
);

  logic [ADDR_W-1:0] base_q, base_nxt, base_adv, stride;
  logic [SCAN_W-1:0] rs_q, rs_nxt, rs_adv;
  logic [LINE_W-1:0] lc_q, lc_nxt, lc_inc;
  logic              dbl_q, dbl_nxt, hp_q, hp_nxt;
  logic              step_ok, adv, row_end, split_hit;

  assign lc_inc    = lc_q + 1'b1;
  assign split_hit = (lc_inc == line_cmp);
  assign step_ok   = ~dbl_scan | dbl_q;
  assign adv       = step_ok & (~scan_half | hp_q);
  assign row_end   = (rs_q == max_scan);
  assign stride    = ADDR_W'(line_offset) << unit_shift(unit);
  assign base_adv  = (adv && row_end) ? base_q + stride : base_q;
  assign rs_adv    = adv ? (row_end ? '0 : rs_q + 1'b1) : rs_q;

  always_comb begin
    base_nxt = base_q;
    rs_nxt   = rs_q;
    lc_nxt   = lc_q;
    dbl_nxt  = dbl_q;
    hp_nxt   = hp_q;
    if (frame_start) begin
      base_nxt = start_addr;
      rs_nxt   = preset_scan;
      lc_nxt   = '0;
      dbl_nxt  = 1'b0;
      hp_nxt   = 1'b0;
    end else if (line_start) begin
      lc_nxt = lc_inc;
      if (split_hit) begin
        base_nxt = '0;
        rs_nxt   = '0;
        dbl_nxt  = 1'b0;
        hp_nxt   = 1'b0;
      end else begin
        base_nxt = base_adv;
        rs_nxt   = rs_adv;
        dbl_nxt  = dbl_scan & ~dbl_q;
        hp_nxt   = (step_ok & scan_half) ? ~hp_q : hp_q;
      end
    end
  end

  assign load_en  = run & (frame_start | line_start);
  assign load_val = base_nxt + ADDR_W'(byte_pan);
  assign scan_row = rs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      rs_q   <= '0;
      lc_q   <= '0;
      dbl_q  <= 1'b0;
      hp_q   <= 1'b0;
    end else if (!run) begin
      base_q <= '0;
      rs_q   <= '0;
      lc_q   <= '0;
      dbl_q  <= 1'b0;
      hp_q   <= 1'b0;
    end else begin
      base_q <= base_nxt;
      rs_q   <= rs_nxt;
      lc_q   <= lc_nxt;
      dbl_q  <= dbl_nxt;
      hp_q   <= hp_nxt;
    end
  end

endmodule

// File: rtl/vga_char_ctr.sv
module vga_char_ctr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              char_tick,
  input  logic              char_half,
  output logic [ADDR_W-1:0] char_addr
);

  logic [ADDR_W-1:0] ca_q;
  logic              cp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ca_q <= '0;
      cp_q <= 1'b0;
    end else if (!run) begin
      ca_q <= '0;
      cp_q <= 1'b0;
    end else if (load_en) begin
      ca_q <= load_val;
      cp_q <= 1'b0;
    end else if (char_tick) begin
      if (!char_half || cp_q) ca_q <= ca_q + 1'b1;
      if (char_half) cp_q <= ~cp_q;
    end
  end

  assign char_addr = ca_q;

endmodule

// File: rtl/vga_addr_remap.sv
module vga_addr_remap
  import vga_ag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SCAN_W = 5
) (
  input  addr_unit_e        unit,
  input  logic              wrap_hi,
  input  logic              bank0_n,
  input  logic              bank1_n,
  input  logic [ADDR_W-1:0] char_addr,
  input  logic [SCAN_W-1:0] scan_row,
  output logic [ADDR_W-1:0] mem_addr
);

  localparam int BANK0_BIT = 13;
  localparam int BANK1_BIT = 14;

  logic [ADDR_W-1:0] rot;
  logic              word_lsb;

  assign word_lsb = wrap_hi ? char_addr[ADDR_W-1] : char_addr[BANK0_BIT];

  always_comb begin
    case (unit)
      UNIT_WORD:  rot = {char_addr[ADDR_W-2:0], word_lsb};
      UNIT_DWORD: rot = {char_addr[ADDR_W-3:0], char_addr[ADDR_W-1:ADDR_W-2]};
      default:    rot = char_addr;
    endcase
    mem_addr = rot;
    if (!bank0_n) mem_addr[BANK0_BIT] = scan_row[0];
    if (!bank1_n) mem_addr[BANK1_BIT] = scan_row[1];
  end

endmodule

// File: rtl/vga_fetch_addr.sv
module vga_fetch_addr
  import vga_ag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8,
  parameter int SCAN_W = 5,
  parameter int LINE_W = 10,
  parameter int PAN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              char_tick,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [OFF_W-1:0]  line_offset,
  input  logic [SCAN_W-1:0] preset_scan,
  input  logic [PAN_W-1:0]  byte_pan,
  input  logic [SCAN_W-1:0] max_scan,
  input  logic              dbl_scan,
  input  logic              sel_dword,
  input  logic              sel_byte,
  input  logic              wrap_hi,
  input  logic              bank0_n,
  input  logic              bank1_n,
  input  logic              scan_half,
  input  logic              char_half,
  input  logic              run,
  input  logic [LINE_W-1:0] line_cmp,
  output logic              fetch_valid,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [SCAN_W-1:0] scan_row
);

  addr_unit_e        unit;
  logic              load_en, issue;
  logic [ADDR_W-1:0] load_val, char_addr, mem_addr;
  logic [SCAN_W-1:0] rs;

  assign unit  = pick_unit(sel_dword, sel_byte);
  assign issue = run & char_tick & ~frame_start & ~line_start;

  vga_row_seq #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SCAN_W(SCAN_W), .LINE_W(LINE_W), .PAN_W(PAN_W)
  ) u_rows (
    .clk(clk), .rst_n(rst_n), .run(run),
    .frame_start(frame_start), .line_start(line_start),
    .start_addr(start_addr), .line_offset(line_offset), .unit(unit),
    .preset_scan(preset_scan), .max_scan(max_scan), .dbl_scan(dbl_scan),
    .scan_half(scan_half), .line_cmp(line_cmp), .byte_pan(byte_pan),
    .load_en(load_en), .load_val(load_val), .scan_row(rs)
  );

  vga_char_ctr #(.ADDR_W(ADDR_W)) u_chars (
    .clk(clk), .rst_n(rst_n), .run(run),
    .load_en(load_en), .load_val(load_val),
    .char_tick(issue), .char_half(char_half),
    .char_addr(char_addr)
  );

  vga_addr_remap #(.ADDR_W(ADDR_W), .SCAN_W(SCAN_W)) u_map (
    .unit(unit), .wrap_hi(wrap_hi), .bank0_n(bank0_n), .bank1_n(bank1_n),
    .char_addr(char_addr), .scan_row(rs), .mem_addr(mem_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_valid <= 1'b0;
      fetch_addr  <= '0;
    end else begin
      fetch_valid <= issue;
      if (issue) fetch_addr <= mem_addr;
    end
  end

  assign scan_row = rs;

endmodule

// File: rtl/vga_fetch_addr_chk.sv
module vga_fetch_addr_chk #(
  parameter int ADDR_W = 16,
  parameter int SCAN_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              line_start,
  input logic              char_tick,
  input logic              run,
  input logic              bank0_n,
  input logic              bank1_n,
  input logic [SCAN_W-1:0] preset_scan,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [SCAN_W-1:0] scan_row
);

  // R1: a stopped block emits nothing and shows row scan zero
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!fetch_valid && scan_row == '0));

  // R2: frame strobe loads the preset row scan
  a_r2_preset_load: assert property (@(posedge clk) disable iff (!rst_n)
    (run && frame_start) |=> scan_row == $past(preset_scan));

  // R3: a valid beat follows a character tick
  a_r3_valid_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> $past(char_tick));

  // R6: bank substitution carries the row-scan bits
  a_r6_bank0_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !$past(bank0_n)) |-> fetch_addr[13] == $past(scan_row[0]));

  a_r6_bank1_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !$past(bank1_n)) |-> fetch_addr[14] == $past(scan_row[1]));

  // R10: a tick colliding with a reload strobe is dropped
  a_r10_strobe_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start || line_start) |=> !fetch_valid);

endmodule

bind vga_fetch_addr vga_fetch_addr_chk #(.ADDR_W(ADDR_W), .SCAN_W(SCAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
  .char_tick(char_tick), .run(run), .bank0_n(bank0_n), .bank1_n(bank1_n),
  .preset_scan(preset_scan), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
  .scan_row(scan_row)
);

// File: tb/sim_vga_fetch_addr.sv
module sim_vga_fetch_addr;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 0, line_start = 0, char_tick = 0;
  logic [15:0] start_addr = 0;
  logic [7:0]  line_offset = 0;
  logic [4:0]  preset_scan = 0, max_scan = 0;
  logic [1:0]  byte_pan = 0;
  logic        dbl_scan = 0, sel_dword = 0, sel_byte = 1, wrap_hi = 0;
  logic        bank0_n = 1, bank1_n = 1, scan_half = 0, char_half = 0, run = 0;
  logic [9:0]  line_cmp = 10'h3ff;
  logic        fetch_valid;
  logic [15:0] fetch_addr;
  logic [4:0]  scan_row;

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #5 clk = ~clk;

  vga_fetch_addr u0 (.*);

  // ---------------- behavioural reference ----------------
  int m_base, m_lin, m_rs, m_lc, m_dbl, m_hp, m_cp, m_ev, m_ea;

  function automatic int remap(int lin, int rs);
    int a, k;
    a = lin & 16'hffff;
    if (sel_dword) a = ((a << 2) | (a >> 14)) & 16'hffff;
    else if (!sel_byte) a = ((a << 1) | (wrap_hi ? (a >> 15) & 1 : (a >> 13) & 1)) & 16'hffff;
    if (!bank0_n) a = (a & ~(1 << 13)) | ((rs & 1) << 13);
    if (!bank1_n) a = (a & ~(1 << 14)) | (((rs >> 1) & 1) << 14);
    return a;
  endfunction

  task automatic model_step();
    int k, adv;
    if (!rst_n || !run) begin
      m_base = 0; m_lin = 0; m_rs = 0; m_lc = 0; m_dbl = 0; m_hp = 0; m_cp = 0; m_ev = 0;
    end else if (frame_start) begin
      m_base = start_addr; m_lin = (start_addr + byte_pan) & 16'hffff;
      m_rs = preset_scan; m_lc = 0; m_dbl = 0; m_hp = 0; m_cp = 0; m_ev = 0;
    end else if (line_start) begin
      m_ev = 0; m_cp = 0;
      m_lc = (m_lc + 1) % 1024;
      if (m_lc == line_cmp) begin
        m_base = 0; m_rs = 0; m_dbl = 0; m_hp = 0;
      end else begin
        if (dbl_scan && !m_dbl) begin m_dbl = 1; adv = 0; end
        else begin m_dbl = 0; adv = 1; end
        if (adv && scan_half) begin adv = m_hp; m_hp = 1 - m_hp; end
        if (adv) begin
          k = sel_dword ? 8 : (sel_byte ? 2 : 4);
          if (m_rs == max_scan) begin m_rs = 0; m_base = (m_base + line_offset * k) & 16'hffff; end
          else m_rs = (m_rs + 1) & 31;
        end
      end
      m_lin = (m_base + byte_pan) & 16'hffff;
    end else if (char_tick) begin
      m_ev = 1; m_ea = remap(m_lin, m_rs);
      if (char_half) begin
        if (m_cp) m_lin = (m_lin + 1) & 16'hffff;
        m_cp = 1 - m_cp;
      end else m_lin = (m_lin + 1) & 16'hffff;
    end else m_ev = 0;
  endtask

  always begin
    @(posedge clk);
    model_step();
    cyc++;
    #2;
    if (!done) begin
      n_cmp++;
      if (fetch_valid !== m_ev[0] || scan_row !== m_rs[4:0] ||
          (m_ev && fetch_addr !== m_ea[15:0])) begin
        n_bad++;
        $display("FAIL %s cyc %0d: valid/addr/scan act %0b/%h/%0d exp %0b/%h/%0d",
                 cur_req, cyc, fetch_valid, fetch_addr, scan_row,
                 m_ev[0], m_ea[15:0], m_rs[4:0]);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic pulse(input bit fs, input bit ls, input bit ct);
    @(negedge clk);
    frame_start = fs; line_start = ls; char_tick = ct;
  endtask

  task automatic frame(input int lines, input int ticks, input bit collide);
    pulse(1, 0, 0);
    for (int l = 0; l < lines; l++) begin
      for (int t = 0; t < ticks; t++) pulse(0, 0, (t % 3) != 2);
      pulse(0, 1, collide);
    end
    pulse(0, 0, 0);
  endtask

  task automatic cfg(input bit dw, input bit by, input bit wh, input bit b0n, input bit b1n,
                     input bit ds, input bit sh, input bit ch);
    @(negedge clk);
    sel_dword = dw; sel_byte = by; wrap_hi = wh; bank0_n = b0n; bank1_n = b1n;
    dbl_scan = ds; scan_half = sh; char_half = ch;
  endtask

  // watchdog
  initial begin
    #1500000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: act running exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    run = 1;
    // R2/R3/R4: byte unit linear addressing, text rows with preset and pan
    cur_req = "R2";
    start_addr = 16'h1234; line_offset = 8'd40; preset_scan = 5'd3; max_scan = 5'd7; byte_pan = 2'd2;
    cfg(0, 1, 0, 1, 1, 0, 0, 0);
    frame(12, 8, 0);
    // R7: graphics rows, stride every line, byte unit
    cur_req = "R7";
    max_scan = 0; preset_scan = 0; byte_pan = 0;
    frame(6, 6, 0);
    // R5: word unit, both low-bit sources, high start address
    cur_req = "R5";
    start_addr = 16'hA5F0; line_offset = 8'd3;
    cfg(0, 0, 0, 1, 1, 0, 0, 0); frame(5, 9, 0);
    cfg(0, 0, 1, 1, 1, 0, 0, 0); frame(5, 9, 0);
    // R4: doubleword wins over byte select
    cur_req = "R4";
    start_addr = 16'hC003; line_offset = 8'd5;
    cfg(1, 1, 0, 1, 1, 0, 0, 0); frame(5, 7, 0);
    // R6: two- and four-bank interleave
    cur_req = "R6";
    start_addr = 16'h0100; max_scan = 5'd3; line_offset = 8'd20;
    cfg(0, 1, 0, 0, 1, 0, 0, 0); frame(8, 5, 0);
    cfg(0, 1, 0, 0, 0, 0, 0, 0); frame(8, 5, 0);
    // R8: doubling and half-rate rows
    cur_req = "R8";
    max_scan = 5'd1;
    cfg(0, 1, 0, 1, 1, 1, 0, 0); frame(8, 4, 0);
    cfg(0, 1, 0, 1, 1, 0, 1, 0); frame(8, 4, 0);
    cfg(0, 1, 0, 1, 1, 1, 1, 0); frame(10, 4, 0);
    // R3: half-rate character stepping
    cur_req = "R3";
    cfg(0, 0, 0, 1, 1, 0, 0, 1); frame(4, 11, 0);
    // R9: split on the line that also ends a row (max_scan 3, compare at 4)
    cur_req = "R9";
    start_addr = 16'h4000; max_scan = 5'd3; line_cmp = 10'd4; byte_pan = 2'd1;
    cfg(0, 1, 0, 1, 1, 0, 0, 0); frame(12, 5, 0);
    line_cmp = 10'd6; cfg(0, 0, 0, 0, 1, 1, 1, 0); frame(12, 5, 0);
    // R10: ticks colliding with line and frame strobes
    cur_req = "R10";
    line_cmp = 10'h3ff;
    frame(6, 4, 1);
    pulse(1, 1, 1); pulse(0, 0, 1); pulse(0, 1, 1); pulse(0, 0, 1); pulse(0, 0, 0);
    // R1: run dropped mid-frame clears everything
    cur_req = "R1";
    pulse(1, 0, 0); pulse(0, 1, 0); pulse(0, 0, 1);
    @(negedge clk); run = 0; char_tick = 1;
    pulse(0, 1, 1); pulse(0, 0, 1); pulse(0, 0, 0);
    @(negedge clk); run = 1;
    // mixed random traffic over all modes
    cur_req = "R7";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (i % 200 == 0) begin
        {sel_dword, sel_byte, wrap_hi, bank0_n, bank1_n, dbl_scan, scan_half, char_half} = 8'($urandom);
        start_addr = 16'($urandom); line_offset = 8'($urandom); preset_scan = 5'($urandom % 8);
        max_scan = 5'($urandom % 8); byte_pan = 2'($urandom); line_cmp = 10'($urandom % 24);
      end
      frame_start = ($urandom % 97) == 0;
      line_start  = ($urandom % 9) == 0;
      char_tick   = ($urandom % 3) != 0;
    end
    pulse(0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule